// File: doc/BRIEF.md
# Configurable Registered Buffer with Even-Parity Check

This block is the clocked address and command register of a registered memory module. Every rising clock edge it captures a 25-bit input word. A two-bit mode input picks how the captured word reaches the 28-bit output bus. In the wide layout, 25 inputs each drive one output. In the paired layout, 14 inputs each drive two identical output copies. The mode also says whether a paired device is the first (A) or the second (B) register of a cascaded pair. Two active-low chip-select inputs gate the output register: when neither is asserted, the outputs keep their value.

The block checks even parity over a fixed group of inputs that does not depend on the module. The parity bit comes from the controller one cycle after the data. In a cascaded pair, the A device does not flag errors. It passes its partial result (its data bits XOR the parity bit) to the B device on a partial-parity output. The B device combines that result with its own data bits and drives the single active-low error flag. Once the flag asserts, it stays low for at least two cycles.

Top module: `cfgRegBuf`

## Requirements
- R1: With modeSel[0]=0 (wide layout) and at least one csN bit low at an edge, qOut[24:0] equals the dIn value sampled at that edge and qOut[27:25] is 0.
- R2: With modeSel[0]=1 (paired layout), qOut[13:0] and qOut[27:14] both equal dIn[13:0] from the last capturing edge, and dIn[24:14] has no effect on qOut.
- R3: When both csN bits are high at an edge, qOut does not change at that edge.
- R4: The checked bits are dIn[21:0] in the wide layout and dIn[10:0] in the paired layout. For data captured at edge k, the parity bit is sampled at edge k+1, and qerrN goes low at edge k+2 if the checked bits plus the parity bit hold an odd number of ones (wide layout).
- R5: Data captured at an edge where both csN bits are high is never checked: the qerrN update two edges later keeps the previous level.
- R6: After qerrN goes low, it stays low for at least two clock cycles. It releases only at a checked update with no error.
- R7: In mode A (modeSel=2'b01), qerrN stays high and pparOut goes, at edge k+1, to the XOR of the checked bits captured at edge k and parIn sampled at edge k+1.
- R8: In mode B (modeSel=2'b11), parIn is ignored. The error for data captured at edge k is the XOR of its checked bits and pparIn sampled at edge k+2, and qerrN updates at that same edge.
- R9: While rstN is low, qOut is 0, qerrN is 1 and pparOut is 0.
- R10: In the wide layout (modeSel=2'b00 or 2'b10), pparOut is 0 and pparIn has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Layout and cascade role: bit0 = paired, bit1 = role B when paired |
| csN | input | 2 | Active-low chip selects; any low bit enables capture and checking |
| dIn | input | 25 | Data inputs |
| parIn | input | 1 | Parity bit from the controller, one cycle behind its data |
| pparIn | input | 1 | Partial parity from the A device (used in mode B) |
| qOut | output | 28 | Registered outputs (wide: bits 24:0; paired: two 14-bit copies) |
| pparOut | output | 1 | Partial parity to the B device (driven in mode A) |
| qerrN | output | 1 | Active-low parity error flag |

## Verification
The assertions watch these properties on every cycle:
- outputs follow the captured data in both layouts;
- outputs freeze when no chip select is active;
- the error flag stays low for at least two cycles once it asserts;
- a falling error flag always traces back to a selected data cycle;
- the A role never flags an error;
- the wide layout keeps pparOut at zero.

Only the bench scenarios can show the parts that need an independent parity model: the two-cycle pipeline alignment of data, parity bit and cascade input; the choice of checked bits in each layout; and the release timing of the error flag under mixed selected and unselected cycles.

// File: rtl/cfgRegBufPkg.sv
package cfgRegBufPkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic captureEn;  // load output register and parity stage
    logic narrow;     // paired (1:2) output layout
    logic useParIn;   // fold controller parity bit into partial result
    logic usePparIn;  // fold cascade input into final comparison
    logic drivePpar;  // expose partial result on cascade output
  } strobeT;

endpackage

// File: rtl/cfgRegBufCtrl.sv
module cfgRegBufCtrl
  import cfgRegBufPkg::*;
#(
  parameter int CS_W    = 2,
  parameter int MIN_LOW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      modeSel,
  input  logic [CS_W-1:0] csN,
  input  logic            mismatch,
  output strobeT          st,
  output logic            qerrN
);

  localparam int CNT_W = $clog2(MIN_LOW + 1);

  logic pairMode;
  logic roleA;
  logic roleB;
  logic csActive;
  logic vld1;
  logic vld2;
  logic evalEn;
  logic [CNT_W-1:0] lowCnt;

  assign pairMode = modeSel[0];
  assign roleA    = modeSel[0] & ~modeSel[1];
  assign roleB    = modeSel[0] & modeSel[1];
  assign csActive = ~(&csN);

  // Track which pipeline slots carry selected (checkable) data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld1 <= 1'b0;
      vld2 <= 1'b0;
    end else begin
      vld1 <= csActive;
      vld2 <= vld1;
    end
  end

  assign evalEn = vld2 & ~roleA;

  always_comb begin
    st.captureEn = csActive;
    st.narrow    = pairMode;
    st.useParIn  = ~roleB;
    st.usePparIn = roleB;
    st.drivePpar = roleA;
  end

  // Error flag with minimum low time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qerrN  <= 1'b1;
      lowCnt <= '0;
    end else begin
      if (lowCnt != '0) lowCnt <= lowCnt - 1'b1;
      if (evalEn) begin
        if (mismatch) begin
          qerrN  <= 1'b0;
          lowCnt <= CNT_W'(MIN_LOW - 1);
        end else if (lowCnt == '0) begin
          qerrN <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cfgRegBufData.sv
module cfgRegBufData
  import cfgRegBufPkg::*;
#(
  parameter int WIDE_W     = 25,
  parameter int NARROW_W   = 14,
  parameter int CHK_WIDE   = 22,
  parameter int CHK_NARROW = 11,
  parameter int OUT_W      = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            st,
  input  logic [WIDE_W-1:0] dIn,
  input  logic              parIn,
  input  logic              pparIn,
  output logic [OUT_W-1:0]  qOut,
  output logic              pparOut,
  output logic              mismatch
);

  localparam int COPIES = 2;
  localparam logic [WIDE_W-1:0] MASK_WIDE =
    {{(WIDE_W - CHK_WIDE){1'b0}}, {CHK_WIDE{1'b1}}};
  localparam logic [WIDE_W-1:0] MASK_NARROW =
    {{(WIDE_W - CHK_NARROW){1'b0}}, {CHK_NARROW{1'b1}}};

  logic [WIDE_W-1:0]          qReg;
  logic [COPIES*NARROW_W-1:0] fanOut;
  logic [WIDE_W-1:0]          chkMask;
  logic                       xorReg;
  logic                       partReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            qReg <= '0;
    else if (st.captureEn) qReg <= dIn;
  end

  // Paired layout: replicate the narrow slice onto every copy
  for (genvar c = 0; c < COPIES; c++) begin : gCopy
    assign fanOut[c*NARROW_W +: NARROW_W] = qReg[NARROW_W-1:0];
  end

  assign qOut = st.narrow ? OUT_W'(fanOut) : OUT_W'(qReg);

  // Parity pipeline: data fold, then parity bit, then cascade
  assign chkMask = st.narrow ? MASK_NARROW : MASK_WIDE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xorReg  <= 1'b0;
      partReg <= 1'b0;
    end else begin
      xorReg  <= ^(dIn & chkMask);
      partReg <= xorReg ^ (st.useParIn & parIn);
    end
  end

  assign mismatch = partReg ^ (st.usePparIn & pparIn);
  assign pparOut  = st.drivePpar & partReg;

endmodule

// File: rtl/cfgRegBuf.sv
module cfgRegBuf
  import cfgRegBufPkg::*;
#(
  parameter int WIDE_W     = 25,
  parameter int NARROW_W   = 14,
  parameter int CHK_WIDE   = 22,
  parameter int CHK_NARROW = 11,
  parameter int CS_W       = 2,
  parameter int MIN_LOW    = 2,
  parameter int OUT_W      = (WIDE_W > 2*NARROW_W) ? WIDE_W : 2*NARROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [CS_W-1:0]   csN,
  input  logic [WIDE_W-1:0] dIn,
  input  logic              parIn,
  input  logic              pparIn,
  output logic [OUT_W-1:0]  qOut,
  output logic              pparOut,
  output logic              qerrN
);

  strobeT st;
  logic   mismatch;

  cfgRegBufCtrl #(
    .CS_W    (CS_W),
    .MIN_LOW (MIN_LOW)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .csN      (csN),
    .mismatch (mismatch),
    .st       (st),
    .qerrN    (qerrN)
  );

  cfgRegBufData #(
    .WIDE_W     (WIDE_W),
    .NARROW_W   (NARROW_W),
    .CHK_WIDE   (CHK_WIDE),
    .CHK_NARROW (CHK_NARROW),
    .OUT_W      (OUT_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .dIn      (dIn),
    .parIn    (parIn),
    .pparIn   (pparIn),
    .qOut     (qOut),
    .pparOut  (pparOut),
    .mismatch (mismatch)
  );

endmodule

// File: rtl/cfgRegBufChk.sv
module cfgRegBufChk #(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int CS_W     = 2,
  parameter int OUT_W    = 28
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic [CS_W-1:0]   csN,
  input logic [WIDE_W-1:0] dIn,
  input logic [OUT_W-1:0]  qOut,
  input logic              pparOut,
  input logic              qerrN
);

  AST_WIDE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel[0] && !(&csN)) |=> (qOut[WIDE_W-1:0] == $past(dIn))); // R1

  AST_PAIR_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[0] && !(&csN)) |=>
      ((qOut[NARROW_W-1:0] == $past(dIn[NARROW_W-1:0])) &&
       (qOut[2*NARROW_W-1:NARROW_W] == $past(dIn[NARROW_W-1:0])))); // R2

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |=> $stable(qOut)); // R3

  AST_FLAG_FROM_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(qerrN) |-> $past(!(&csN), 3)); // R5

  AST_FLAG_MIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(qerrN) |=> !qerrN); // R6

  AST_ROLE_A_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01) |-> qerrN); // R7

  AST_WIDE_NO_PPAR: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel[0] |-> !pparOut); // R10

endmodule

bind cfgRegBuf cfgRegBufChk #(
  .WIDE_W   (WIDE_W),
  .NARROW_W (NARROW_W),
  .CS_W     (CS_W),
  .OUT_W    (OUT_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .modeSel (modeSel),
  .csN     (csN),
  .dIn     (dIn),
  .qOut    (qOut),
  .pparOut (pparOut),
  .qerrN   (qerrN)
);

// File: tb/tb_cfgRegBuf.sv
module tb_cfgRegBuf;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_LOW    = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [1:0]  csN = 2'b11;
  logic [24:0] dIn = '0;
  logic        parIn = 1'b0;
  logic        pparIn = 1'b0;
  logic [27:0] qOut;
  logic        pparOut;
  logic        qerrN;

  int    checks = 0;
  int    errors = 0;
  bit    checkOn = 1'b0;
  string phaseTag = "R9";

  // Reference model state
  logic [24:0] mCap;
  logic        mX1, mV1, mP2, mV2, mQerr;
  int          mAge;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgRegBuf dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .dIn(dIn),
    .parIn(parIn), .pparIn(pparIn), .qOut(qOut), .pparOut(pparOut),
    .qerrN(qerrN)
  );

  function automatic int chkWidth(logic [1:0] m);
    return m[0] ? 11 : 22;
  endfunction

  function automatic logic oddOnes(logic [24:0] v, int w);
    int cnt = 0;
    for (int i = 0; i < w; i++) if (v[i]) cnt++;
    return (cnt % 2) == 1;
  endfunction

  function automatic logic [27:0] expQ();
    logic [27:0] r = '0;
    if (modeSel[0]) begin
      for (int i = 0; i < 14; i++) begin
        r[i]      = mCap[i];
        r[i + 14] = mCap[i];
      end
    end else begin
      for (int i = 0; i < 25; i++) r[i] = mCap[i];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCap = '0; mX1 = 0; mV1 = 0; mP2 = 0; mV2 = 0; mQerr = 1; mAge = 0;
    end else begin
      logic errBit, evalNow;
      errBit  = mP2 ^ ((modeSel == 2'b11) ? pparIn : 1'b0);
      evalNow = mV2 && (modeSel != 2'b01);
      if (mAge < 1000) mAge++;
      if (evalNow) begin
        if (errBit) begin
          mQerr = 0;
          mAge  = 0;
        end else if (mAge >= MIN_LOW) begin
          mQerr = 1;
        end
      end
      mP2 = mX1 ^ ((modeSel != 2'b11) ? parIn : 1'b0);
      mV2 = mV1;
      mX1 = oddOnes(dIn, chkWidth(modeSel));
      mV1 = (csN != 2'b11);
      if (csN != 2'b11) mCap = dIn;
    end
  end

  task automatic check(string tag, string what, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checkOn && rstN) begin
      check(phaseTag, "qOut", qOut, expQ());
      check(phaseTag, "pparOut", {27'b0, pparOut},
            {27'b0, (modeSel == 2'b01) ? mP2 : 1'b0});
      check(phaseTag, "qerrN", {27'b0, qerrN}, {27'b0, mQerr});
    end
  end

  task automatic doReset(logic [1:0] m);
    @(negedge clk);
    checkOn = 1'b0;
    rstN    = 1'b0;
    modeSel = m;
    csN     = 2'b11;
    repeat (2) @(negedge clk);
    // R9: reset values at the ports
    check("R9", "qOut reset", qOut, 28'h0);
    check("R9", "qerrN reset", {27'b0, qerrN}, 28'h1);
    check("R9", "pparOut reset", {27'b0, pparOut}, 28'h0);
    rstN    = 1'b1;
    checkOn = 1'b1;
  endtask

  task automatic runPhase(string tag, logic [1:0] m, int n, int csOffPct, int errPct);
    logic [24:0] prevD  = '0;
    logic [24:0] prev2D = '0;
    doReset(m);
    phaseTag = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dIn = 25'($urandom);
      if (($urandom % 100) < csOffPct) csN = 2'b11;
      else csN = 2'($urandom % 3);
      parIn = oddOnes(prevD, chkWidth(m)) ^ (($urandom % 100) < errPct);
      if (m == 2'b11) begin
        parIn  = 1'($urandom);  // R8: ignored in role B
        pparIn = oddOnes(prev2D, chkWidth(m)) ^ (($urandom % 100) < errPct);
      end else begin
        pparIn = 1'($urandom);  // R10: no effect outside role B
      end
      prev2D = prevD;
      prevD  = dIn;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    runPhase("R1",  2'b00, 300, 0,  0);
    runPhase("R3",  2'b00, 300, 50, 0);
    runPhase("R4",  2'b00, 400, 10, 20);
    runPhase("R5",  2'b00, 300, 70, 50);
    runPhase("R6",  2'b00, 300, 0,  8);
    runPhase("R10", 2'b10, 300, 20, 20);
    runPhase("R2",  2'b01, 300, 20, 0);
    runPhase("R7",  2'b01, 300, 20, 30);
    runPhase("R8",  2'b11, 400, 20, 25);
    doReset(2'b00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule